// File: doc/BRIEF.md
# I2C EEPROM Target with Read Engine

This block is an I2C target that fronts a 512-byte, 8-bit-wide storage array. It oversamples the SCL and SDA lines with the system clock and recognises START, repeated START and STOP conditions. It answers only to its own device address and pulls SDA low through an open-drain enable output. The bus master reads bytes in three ways. A current-address read returns data from an address pointer that persists between transactions. A random read first sets that pointer with an address-only write and then issues a repeated START and a read. A sequential burst continues for as long as the master acknowledges each byte.

Byte and page writes are also supported, so that data read back can be compared with data written. Writes advance the pointer inside a 16-byte page. Reads advance it across the whole array. The master supplies the ninth address bit through a block-select bit in the device byte.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the target does not pull SDA low (sda_oe_o is 0). The target is idle and the address pointer is 0.
- R2: The device byte is matched as follows. Bits [7:4] must equal 4'b1010 and bits [3:2] must equal hw_sel_i. Bit [1] is the block-select bit and bit [0] is R/W, where 1 means read. A matching device byte is acknowledged by pulling SDA low during the ninth SCL pulse.
- R3: A device byte that does not match is not acknowledged. All later bus activity is ignored until the next START, and no storage location changes.
- R4: In a write (R/W=0), the byte after the device byte is acknowledged and loaded into the pointer. That byte supplies address bits [7:0], and the block-select bit supplies bit [8].
- R5: Each further byte of a write is stored at the pointer and acknowledged. The pointer then advances with bits [3:0] wrapping inside the current 16-byte page.
- R6: In a read, the target sends the byte at the pointer most significant bit first. Each bit appears on SDA after SCL falls.
- R7: A current-address read starts at the pointer left by the previous transaction. After a write, that is one past the last byte written. After a read, it is one past the last byte sent.
- R8: A random read has three steps: an address-only write, a repeated START, and a matching read device byte. It is acknowledged and returns the byte at the newly loaded address.
- R9: After every byte sent, the pointer advances over the full 9-bit range, from 511 to 0. When the master acknowledges (SDA low on the ninth pulse), the next byte follows.
- R10: After a master NACK the target releases SDA and drives nothing until a START. A STOP returns it to idle.
- R11: sda_oe_o changes only while SCL is low.
- R12: The block-select bit distinguishes locations N and N+256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| hw_sel_i | input | HW_SEL_W (2) | Hardware-select bits compared with device byte bits [3:2] |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The bench builds the block with its default parameters: 512 bytes, a 16-byte page, two synchroniser stages, and hw_sel_i tied to 2'b01. Because the array is only 512 bytes, a short burst starting near location 510 crosses the wrap from 511 to 0. A five-byte page write starting at offset 14 crosses the page wrap. The block-select bit reaches the upper half of the array without long transfers. A device byte with the wrong hardware-select value exercises the ignore path, and its lack of effect is then confirmed by reading back the location it tried to overwrite.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_AW,
        S_DEV_ACK,
        S_ADR,
        S_ADR_AW,
        S_ADR_ACK,
        S_WR,
        S_WR_AW,
        S_WR_ACK,
        S_RD,
        S_RACK,
        S_RACK_F,
        S_IGN
    } tgt_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int LEN = STAGES + 1;

    typedef struct packed {
        logic [LEN-1:0] scl;
        logic [LEN-1:0] sda;
    } line_t;

    line_t d, q;

    always_comb begin
        d     = q;
        d.scl = {q.scl[LEN-2:0], scl_i};
        d.sda = {q.sda[LEN-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.scl <= '1;
            q.sda <= '1;
        end else begin
            q <= d;
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;

    always_comb begin
        scl_now   = q.scl[LEN-2];
        scl_old   = q.scl[LEN-1];
        sda_now   = q.sda[LEN-2];
        sda_old   = q.sda[LEN-1];
        sda_s     = sda_now;
        scl_rise  = scl_now & ~scl_old;
        scl_fall  = ~scl_now & scl_old;
        start_evt = scl_now & scl_old & sda_old & ~sda_now;
        stop_evt  = scl_now & scl_old & ~sda_old & sda_now;
    end
endmodule

// File: rtl/i2c_tgt_store.sv
module i2c_tgt_store #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = cells[raddr];
    end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_tgt_pkg::*;
#(
    parameter int         MEM_DEPTH   = 512,
    parameter int         PAGE_BYTES  = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_ID      = 4'b1010,
    parameter int         HW_SEL_W    = 3 - ($clog2(MEM_DEPTH) - 8)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [HW_SEL_W-1:0] hw_sel_i,
    output logic                sda_oe_o
);
    localparam int ADDR_W = $clog2(MEM_DEPTH);
    localparam int BLK_W  = ADDR_W - 8;
    localparam int PG_W   = $clog2(PAGE_BYTES);

    typedef struct packed {
        tgt_state_e        st;
        logic [2:0]        cnt;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] ptr;
        logic [BLK_W-1:0]  blk;
        logic              rw;
        logic              oe;
        logic              mack;
    } ctx_t;

    ctx_t d, q;

    logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    logic              mem_we;
    logic [7:0]        rd_data;
    logic [7:0]        byte_in;
    logic [ADDR_W-1:0] ptr_w;
    tgt_state_e        st_w;
    logic              dev_match;

    i2c_tgt_store #(.DEPTH(MEM_DEPTH), .DATA_W(8), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (ptr_w),
        .wdata (byte_in),
        .raddr (ptr_w),
        .rdata (rd_data)
    );

    always_comb begin
        ptr_w     = q.ptr;
        st_w      = q.st;
        byte_in   = {q.sh[6:0], sda_s};
        dev_match = (byte_in[7:4] == DEV_ID) && (byte_in[3 -: HW_SEL_W] == hw_sel_i);
    end

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        if (stop_evt) begin
            d.st  = S_IDLE;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else if (start_evt) begin
            d.st  = S_DEV;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else begin
            case (q.st)
                S_DEV: begin
                    if (scl_rise) begin
                        d.sh  = byte_in;
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) begin
                            if (dev_match) begin
                                d.rw  = byte_in[0];
                                d.blk = byte_in[BLK_W:1];
                                d.st  = S_DEV_AW;
                            end else begin
                                d.st = S_IGN;
                            end
                        end
                    end
                end
                S_DEV_AW: begin
                    if (scl_fall) begin
                        d.oe = 1'b1;
                        d.st = S_DEV_ACK;
                    end
                end
                S_DEV_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.sh = rd_data;
                            d.oe = ~rd_data[7];
                            d.st = S_RD;
                        end else begin
                            d.oe = 1'b0;
                            d.st = S_ADR;
                        end
                    end
                end
                S_ADR: begin
                    if (scl_rise) begin
                        d.sh  = byte_in;
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) begin
                            d.ptr = {q.blk, byte_in};
                            d.st  = S_ADR_AW;
                        end
                    end
                end
                S_ADR_AW: begin
                    if (scl_fall) begin
                        d.oe = 1'b1;
                        d.st = S_ADR_ACK;
                    end
                end
                S_ADR_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = S_WR;
                    end
                end
                S_WR: begin
                    if (scl_rise) begin
                        d.sh  = byte_in;
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) begin
                            mem_we = 1'b1;
                            d.ptr  = {q.ptr[ADDR_W-1:PG_W], q.ptr[PG_W-1:0] + PG_W'(1)};
                            d.st   = S_WR_AW;
                        end
                    end
                end
                S_WR_AW: begin
                    if (scl_fall) begin
                        d.oe = 1'b1;
                        d.st = S_WR_ACK;
                    end
                end
                S_WR_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = S_WR;
                    end
                end
                S_RD: begin
                    if (scl_fall) begin
                        if (q.cnt == 3'd7) begin
                            d.oe  = 1'b0;
                            d.ptr = q.ptr + ADDR_W'(1);
                            d.cnt = '0;
                            d.st  = S_RACK;
                        end else begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.oe  = ~q.sh[6];
                            d.cnt = q.cnt + 3'd1;
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                        d.st   = S_RACK_F;
                    end
                end
                S_RACK_F: begin
                    if (scl_fall) begin
                        if (q.mack) begin
                            d.sh  = rd_data;
                            d.oe  = ~rd_data[7];
                            d.cnt = '0;
                            d.st  = S_RD;
                        end else begin
                            d.oe = 1'b0;
                            d.st = S_IGN;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, cnt: '0, sh: '0, ptr: '0, blk: '0, rw: 1'b0, oe: 1'b0, mack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PG_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe_o,
    input tgt_state_e        st_w,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              mem_we,
    input logic [ADDR_W-1:0] ptr_w
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i); // R11

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w == S_IDLE || st_w == S_IGN) |-> !sda_oe_o); // R10

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (st_w == S_IDLE)); // R10

    AST_START_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !stop_evt) |=> (st_w == S_DEV)); // R2

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> $stable(ptr_w[ADDR_W-1:PG_W])); // R5

    AST_WRITE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (st_w == S_WR)); // R4
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk #(.ADDR_W(ADDR_W), .PG_W(PG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe_o  (sda_oe_o),
    .st_w      (st_w),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .mem_we    (mem_we),
    .ptr_w     (ptr_w)
);

// File: tb/i2c_eeprom_target_bench.sv
module i2c_eeprom_target_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = CLK_PERIOD * 10;
    localparam logic [1:0] HW = 2'b01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    i2c_eeprom_target u_i2c_eeprom_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .hw_sel_i (HW),
        .sda_oe_o (sda_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    int oe_viol = 0;
    int mdl [512];
    int mptr = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] act_q [$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R11 monitor: enable may only move while SCL is low
    logic oe_prev = 1'b0;
    always @(posedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && m_scl) oe_viol++;
        oe_prev <= sda_oe;
    end

    // scoreboard monitor
    initial begin
        forever begin
            wait (act_q.size() > 0);
            begin
                logic [7:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, a, e);
            end
        end
    end

    task automatic bus_start();
        m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
    endtask
    task automatic bus_rstart();
        m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
    endtask
    task automatic bus_stop();
        m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #Q;
    endtask
    task automatic send_bit(input logic b);
        m_sda = b; #Q; m_scl = 1'b1; #Q; m_scl = 1'b0; #Q;
    endtask
    task automatic recv_bit(output logic b);
        m_sda = 1'b1; #Q; m_scl = 1'b1; #(Q/2); b = sda_bus; #(Q/2); m_scl = 1'b0; #Q;
    endtask
    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask
    task automatic recv_byte(input logic ack);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        act_q.push_back(v);
        send_bit(~ack);
    endtask

    function automatic logic [7:0] dev(input logic blk, input logic rd);
        return {4'b1010, HW, blk, rd};
    endfunction

    task automatic wr_seq(input logic blk, input logic [7:0] adr, input logic [7:0] data [$]);
        logic ack;
        bus_start();
        send_byte(dev(blk, 1'b0), ack); chk("R2 device ack", ack, 1'b1);
        send_byte(adr, ack);            chk("R4 address ack", ack, 1'b1);
        mptr = {blk, adr};
        foreach (data[i]) begin
            send_byte(data[i], ack);    chk("R5 data ack", ack, 1'b1);
            mdl[mptr] = data[i];
            mptr = (mptr & 9'h1F0) | ((mptr + 1) & 9'h00F);
        end
        bus_stop();
    endtask

    task automatic read_tail(input int n, input string tag);
        logic [7:0] idle;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(mdl[mptr][7:0]);
            tag_q.push_back(tag);
            mptr = (mptr + 1) % 512;
            recv_byte(i < n - 1);
        end
        for (int i = 7; i >= 0; i--) recv_bit(idle[i]);
        chk("R10 released after NACK", idle, 8'hFF);
        bus_stop();
        #Q;
        chk("R10 idle after STOP", sda_oe, 1'b0);
    endtask

    task automatic rd_rand(input logic blk, input logic [7:0] adr, input int n, input string tag);
        logic ack;
        bus_start();
        send_byte(dev(blk, 1'b0), ack); chk("R2 device ack", ack, 1'b1);
        send_byte(adr, ack);            chk("R4 address ack", ack, 1'b1);
        mptr = {blk, adr};
        bus_rstart();
        send_byte(dev(blk, 1'b1), ack); chk("R8 read device ack", ack, 1'b1);
        read_tail(n, tag);
    endtask

    task automatic rd_cur(input int n, input string tag);
        logic ack;
        bus_start();
        send_byte(dev(1'b0, 1'b1), ack); chk("R2 device ack", ack, 1'b1);
        read_tail(n, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 reset releases SDA", sda_oe, 1'b0);

        wr_seq(1'b0, 8'h00, '{8'h3C, 8'h4D});
        wr_seq(1'b1, 8'hFE, '{8'h5A});
        wr_seq(1'b1, 8'hFF, '{8'hA5});
        wr_seq(1'b0, 8'hFE, '{8'h11});
        wr_seq(1'b0, 8'h1E, '{8'h61, 8'h62, 8'h63, 8'h64, 8'h65});

        rd_rand(1'b0, 8'h00, 2, "R6");
        rd_rand(1'b0, 8'h1E, 1, "R8");
        rd_cur(1, "R7");
        rd_rand(1'b0, 8'h10, 3, "R5");
        wr_seq(1'b0, 8'h31, '{8'h81});
        wr_seq(1'b0, 8'h30, '{8'h80});
        rd_cur(1, "R7");
        rd_rand(1'b1, 8'hFE, 3, "R9");
        rd_rand(1'b0, 8'hFE, 1, "R12");

        // R3: foreign hardware-select value must be ignored
        bus_start();
        send_byte({4'b1010, ~HW, 1'b0, 1'b0}, ack); chk("R3 no ack on mismatch", ack, 1'b0);
        send_byte(8'h00, ack);                       chk("R3 address ignored", ack, 1'b0);
        send_byte(8'hEE, ack);                       chk("R3 data ignored", ack, 1'b0);
        bus_stop();
        rd_rand(1'b0, 8'h00, 1, "R3");
        rd_cur(1, "R7");

        wait (act_q.size() == 0);
        #Q;
        chk("R11 enable moved only with SCL low", oe_viol, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule